// File: doc/BRIEF.md
# Clock Mode Switch Controller

The block keeps the clock-mode state of a small processor core: a two-bit divide-select field, a multiplier ratio bit and a multiplier enable bit. Software changes them through a simple write port. The block runs on a reference clock at four times the oscillator rate. From that clock it produces two single-cycle enable pulses: a system-clock tick and a machine-cycle tick, both timed for the active mode. It also reports when the frequency multiplier has locked. Lock is modelled as a fixed countdown after the enable rises.

Divide-select writes are guarded. Any change of the field must pass through the divide-by-four code. The reserved code is never stored. Multiplied operation can only be entered after an ordered handshake on the control register. A write that breaks a rule is dropped without any indication, and the field keeps its value. The timing of a newly accepted mode starts at the next machine-cycle boundary, so the tick pattern never restarts in the middle of a machine cycle.

Write map:
- `wr_addr` = 0 addresses the divide-select field in `wr_data[1:0]`.
- `wr_addr` = 1 addresses the multiplier control register:
  - `wr_data[0]` is the enable.
  - `wr_data[1]` is the ratio, where 1 selects times four and 0 selects times two.

Top module: `clk_mode_ctrl`

## Requirements
- R1: After reset, `div_sel` is 2'b10, and `mult_en`, `ratio_x4` and `mult_ready` are all 0.
- R2: A write of 2'b01 to the divide-select field is dropped, and `div_sel` keeps its value.
- R3: `div_sel` only changes when its old or its new value is 2'b10. A write from 2'b00 to 2'b11, or from 2'b11 to 2'b00, is dropped.
- R4: The system tick period, in reference cycles, depends on the active mode:
  - code 00 with ratio 1: 1
  - code 00 with ratio 0: 2
  - code 10: 4
  - code 11: 2^SLOW_SHIFT (1024 by default)

  The machine tick period is four system tick periods, and every machine tick coincides with a system tick.
- R5: A write of 2'b00 from 2'b10 is accepted only when all of the following have happened in this order, with `regen_mode` low while the field is 10:
  - a control write with enable 0, which is the clear step;
  - a later control write with enable 0, which is the ratio step and sets the ratio;
  - a control write with enable 1;
  - `mult_ready` reading 1.

  Other writes may fall between these steps.
- R6: If the steps of R5 are out of order or skipped, or `regen_mode` is high at the clear step or at the 00 write, a write of 00 is dropped and `div_sel` stays 2'b10. This holds even when `mult_ready` is 1.
- R7: From 2'b00, a single write of 2'b10 is accepted with no handshake.
- R8: `mult_ready` rises exactly LOCK_CYCLES reference cycles after the edge that sets `mult_en`. It falls on the same edge that clears `mult_en`.
- R9: An accepted mode write updates `div_sel` at once. The tick timing keeps the old mode until the current machine cycle ends, and the new timing begins with the next machine cycle.
- R10: A control write that changes the ratio while the enable stays 1 cancels the handshake. A following 00 write is then dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock, four times the oscillator rate |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 1 | 0 = divide-select field, 1 = multiplier control |
| wr_data | input | DW | Write data |
| regen_mode | input | 1 | Regeneration-mode flag; must be 0 for the handshake |
| div_sel | output | 2 | Current divide-select field |
| mult_en | output | 1 | Multiplier enable bit |
| ratio_x4 | output | 1 | Ratio bit (1 = times four) |
| mult_ready | output | 1 | Multiplier locked flag |
| sys_en | output | 1 | System-clock tick, one reference cycle wide |
| mc_en | output | 1 | Machine-cycle tick, one reference cycle wide |

## Verification
On every cycle, the assertions check four things:
- the reserved code never appears in the field;
- every field change touches code 10;
- entry into multiplied mode only follows a ready multiplier;
- the ready flag drops with the enable, and machine ticks land on system ticks.

The ordering of the handshake, the effect of `regen_mode` and of ratio changes, the exact lock delay, the tick periods of each mode and the deferral of a mode change to the machine-cycle boundary are sequence-dependent. The bench scenarios show these, by counting reference cycles between the ticks.

// File: rtl/clk_mode_ctrl.sv
module clk_mode_ctrl #(
  parameter int LOCK_CYCLES = 64,
  parameter int SLOW_SHIFT  = 10,
  parameter int DW          = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic          wr_addr,
  input  logic [DW-1:0] wr_data,
  input  logic          regen_mode,
  output logic [1:0]    div_sel,
  output logic          mult_en,
  output logic          ratio_x4,
  output logic          mult_ready,
  output logic          sys_en,
  output logic          mc_en
);
  localparam int CW = SLOW_SHIFT + 2;
  localparam int LW = $clog2(LOCK_CYCLES + 1);
  localparam logic [1:0] SEL_MUL  = 2'b00;
  localparam logic [1:0] SEL_RSV  = 2'b01;
  localparam logic [1:0] SEL_DIV4 = 2'b10;
  localparam logic [1:0] SEL_SLOW = 2'b11;
  localparam logic [LW-1:0] LOCK_LAST = LW'(LOCK_CYCLES - 1);

  typedef enum logic [1:0] {ST_IDLE, ST_CLR, ST_RATIO, ST_ARMED} step_t;

  step_t step, step_n;
  logic [LW-1:0] lock_cnt;
  logic [CW-1:0] cnt, sys_mask, mc_last;
  logic [1:0] act_sel;
  logic act_ratio, eng_ratio, sel_ok;
  int sh;

  wire sel_wr    = wr_en && !wr_addr;
  wire ctl_wr    = wr_en && wr_addr;
  wire [1:0] new_sel = wr_data[1:0];
  wire new_en    = wr_data[0];
  wire new_ratio = wr_data[1];
  wire at_div4   = (div_sel == SEL_DIV4);
  wire prep_ok   = at_div4 && !regen_mode;
  wire sel_take  = sel_wr && sel_ok;

  always_comb begin
    if (new_sel == SEL_RSV)      sel_ok = 1'b0;
    else if (new_sel == div_sel) sel_ok = 1'b1;
    else if (at_div4)            sel_ok = (new_sel == SEL_SLOW) ||
                                          (step == ST_ARMED && mult_ready && !regen_mode);
    else                         sel_ok = (new_sel == SEL_DIV4);
  end

  always_comb begin
    step_n = step;
    if (ctl_wr) begin
      if (!new_en)
        step_n = !prep_ok ? ST_IDLE : ((mult_en || step == ST_IDLE) ? ST_CLR : ST_RATIO);
      else if (!mult_en)
        step_n = (step == ST_RATIO && prep_ok) ? ST_ARMED : ST_IDLE;
      else if (new_ratio != ratio_x4)
        step_n = ST_IDLE;
    end
    if (sel_take && new_sel != SEL_DIV4) step_n = ST_IDLE;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      div_sel   <= SEL_DIV4;
      mult_en   <= 1'b0;
      ratio_x4  <= 1'b0;
      eng_ratio <= 1'b0;
      step      <= ST_IDLE;
    end else begin
      step <= step_n;
      if (sel_take) begin
        div_sel <= new_sel;
        if (new_sel == SEL_MUL && div_sel != SEL_MUL) eng_ratio <= ratio_x4;
      end
      if (ctl_wr) begin
        mult_en  <= new_en;
        ratio_x4 <= new_ratio;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || (ctl_wr && !new_en)) begin
      lock_cnt   <= '0;
      mult_ready <= 1'b0;
    end else if (mult_en && !mult_ready) begin
      if (lock_cnt == LOCK_LAST) mult_ready <= 1'b1;
      else                       lock_cnt   <= lock_cnt + 1'b1;
    end
  end

  always_comb begin
    case (act_sel)
      SEL_MUL:  sh = act_ratio ? 0 : 1;
      SEL_DIV4: sh = 2;
      default:  sh = SLOW_SHIFT;
    endcase
    sys_mask = (CW'(1) << sh) - CW'(1);
    mc_last  = (CW'(4) << sh) - CW'(1);
  end

  assign sys_en = ((cnt & sys_mask) == sys_mask);
  assign mc_en  = (cnt == mc_last);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt       <= '0;
      act_sel   <= SEL_DIV4;
      act_ratio <= 1'b0;
    end else if (mc_en) begin
      cnt       <= '0;
      act_sel   <= div_sel;
      act_ratio <= eng_ratio;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end

  AST_NO_RESERVED: assert property (@(posedge clk) disable iff (!rst_n)
    div_sel != SEL_RSV); // R2
  AST_VIA_DIV4: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(div_sel) |-> ($past(div_sel) == SEL_DIV4 || div_sel == SEL_DIV4)); // R3
  AST_MUL_AFTER_READY: assert property (@(posedge clk) disable iff (!rst_n)
    (div_sel == SEL_MUL && $past(div_sel) == SEL_DIV4) |-> ($past(mult_ready) && $past(mult_en))); // R5
  AST_READY_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(mult_en) |-> !mult_ready); // R8
  AST_READY_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
    mult_ready |-> mult_en); // R8
  AST_MC_ON_SYS: assert property (@(posedge clk) disable iff (!rst_n)
    mc_en |-> sys_en); // R4
endmodule

// File: tb/tb_clk_mode_ctrl.sv
module tb_clk_mode_ctrl;
  localparam int LOCK = 64;
  logic clk = 1'b0, rst_n = 1'b0, wr_en = 1'b0, wr_addr = 1'b0, regen_mode = 1'b0;
  logic [7:0] wr_data = '0;
  logic [1:0] div_sel;
  logic mult_en, ratio_x4, mult_ready, sys_en, mc_en;
  int checks = 0, failures = 0;

  clk_mode_ctrl #(.LOCK_CYCLES(LOCK), .SLOW_SHIFT(10), .DW(8)) dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .regen_mode(regen_mode), .div_sel(div_sel), .mult_en(mult_en), .ratio_x4(ratio_x4),
    .mult_ready(mult_ready), .sys_en(sys_en), .mc_en(mc_en));

  always #10 clk = ~clk;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic a, input logic [7:0] d);
    @(negedge clk); wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic wait_lock();
    repeat (LOCK + 4) @(negedge clk);
  endtask

  task automatic check_mode(input int p, input string req);
    int last_s = 0, last_m = 0, bad = 0;
    do @(negedge clk); while (!mc_en);
    for (int t = 1; t <= 8 * p; t++) begin
      @(negedge clk);
      if (sys_en) begin
        if (t - last_s != p) bad++;
        last_s = t;
      end
      if (mc_en) begin
        if (t - last_m != 4 * p || !sys_en) bad++;
        last_m = t;
      end
    end
    chk(bad == 0 && last_m == 8 * p, req, bad, 0);
  endtask

  task automatic arm(input logic r);
    wr(1'b1, 8'h00);
    wr(1'b1, {6'd0, r, 1'b0});
    wr(1'b1, {6'd0, r, 1'b1});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    int gap, nsys;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(div_sel == 2'b10 && !mult_en && !ratio_x4 && !mult_ready, "R1", div_sel, 2);
    check_mode(4, "R4 div4");

    wr(1'b0, 8'h01);
    chk(div_sel == 2'b10, "R2 from 10", div_sel, 2);

    wr(1'b1, 8'h00);
    wr(1'b1, 8'h02);
    wr(1'b1, 8'h03);
    repeat (LOCK - 1) @(negedge clk);
    chk(mult_ready == 1'b0, "R8 not yet locked", mult_ready, 0);
    @(negedge clk);
    chk(mult_ready == 1'b1, "R8 locked", mult_ready, 1);
    wr(1'b0, 8'h00);
    chk(div_sel == 2'b00, "R5 x4 entry", div_sel, 0);
    wr(1'b0, 8'h03);
    chk(div_sel == 2'b00, "R3 00 to 11", div_sel, 0);
    wr(1'b0, 8'h01);
    chk(div_sel == 2'b00, "R2 from 00", div_sel, 0);
    check_mode(1, "R4 x4");
    wr(1'b0, 8'h02);
    chk(div_sel == 2'b10, "R7 leave multiplied", div_sel, 2);
    check_mode(4, "R7 div4 timing");

    wr(1'b1, 8'h00);
    chk(mult_ready == 1'b0 && mult_en == 1'b0, "R8 drop with enable", mult_ready, 0);
    wr(1'b1, 8'h00);
    wr(1'b1, 8'h01);
    wait_lock();
    wr(1'b0, 8'h00);
    chk(div_sel == 2'b00, "R5 x2 entry", div_sel, 0);
    check_mode(2, "R4 x2");
    wr(1'b0, 8'h02);

    wr(1'b0, 8'h00);
    chk(div_sel == 2'b10 && mult_ready, "R6 ready without handshake", div_sel, 2);
    wr(1'b1, 8'h00);
    wr(1'b1, 8'h01);
    wait_lock();
    wr(1'b0, 8'h00);
    chk(div_sel == 2'b10, "R6 skipped ratio step", div_sel, 2);

    regen_mode = 1'b1;
    wr(1'b1, 8'h00);
    wr(1'b1, 8'h00);
    regen_mode = 1'b0;
    wr(1'b1, 8'h01);
    wait_lock();
    wr(1'b0, 8'h00);
    chk(div_sel == 2'b10, "R6 regen at clear", div_sel, 2);

    arm(1'b0);
    wait_lock();
    regen_mode = 1'b1;
    wr(1'b0, 8'h00);
    regen_mode = 1'b0;
    chk(div_sel == 2'b10, "R6 regen at entry", div_sel, 2);

    arm(1'b0);
    wait_lock();
    wr(1'b1, 8'h03);
    wr(1'b0, 8'h00);
    chk(div_sel == 2'b10, "R10 ratio change cancels", div_sel, 2);

    check_mode(4, "R9 settle");
    do @(negedge clk); while (!mc_en);
    nsys = 0;
    for (int t = 1; t <= 16; t++) begin
      @(negedge clk);
      if (sys_en != (t % 4 == 0) || mc_en != (t == 16)) nsys++;
      if (t == 5) begin wr_en = 1'b1; wr_addr = 1'b0; wr_data = 8'h03; end
      if (t == 6) wr_en = 1'b0;
    end
    chk(nsys == 0, "R9 old timing to boundary", nsys, 0);
    chk(div_sel == 2'b11, "R9 field updates at once", div_sel, 3);
    gap = 0; nsys = 0;
    do begin
      @(negedge clk); gap++;
      if (sys_en) nsys++;
    end while (!mc_en);
    chk(gap == 4096 && nsys == 4, "R4 slow machine cycle", gap, 4096);

    wr(1'b0, 8'h00);
    chk(div_sel == 2'b11, "R3 11 to 00", div_sel, 3);
    wr(1'b0, 8'h02);
    chk(div_sel == 2'b10, "R3 11 to 10", div_sel, 2);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule